// File: doc/BRIEF.md
# Serial Auto-Increment Register and Bitmap Loader

This block is the write-only serial front end of a two-page bitmap display controller. A host drives three wires into it: an active-low select, a serial clock and a data line. While select is low, the block takes one bit on each rising serial-clock edge and assembles 16-bit words, least significant bit first. The first word after select falls is the start address. Every word after it is data, written to the current address, after which the address steps up by one. Long bursts therefore need only a single address word.

Writes are steered by address. Eight control registers sit at the bottom of the map. Registers 0 and 4 to 7 exist once and are shared by both display pages. Registers 1 to 3 have one copy per page. The bitmap window is also held once per page in external memory, and the block drives its write port. Two enable bits in register 0 choose whether page A, page B or both copies take a paged write. The reserved range between the registers and the bitmap window ignores writes, and so does everything above the window. Both serial inputs are synchronised to the system clock and edge-detected there.

The bitmap write port is a plain one-cycle strobe with no back-pressure. The serial link cannot be stalled, so the memory must accept one write per strobe. The interval between strobes is at least 16 serial-clock periods.

Top module: `serial_reg_loader`

## Requirements
- R1: A bit is taken on each rising edge of `sck` while `cs_n` is low, and each 16-bit word is assembled least significant bit first. For example, the serial bit sequence for 0xA5C3 must not be loaded as 0xC3A5.
- R2: The first complete word after `cs_n` falls sets the address. Each following word is written to the current address, and the address then increments by one.
- R3: Bit 0 of register 0 enables writes to page A and bit 1 enables writes to page B. With both bits set, one data word writes both pages.
- R4: Registers 0, 4, 5, 6 and 7 are shared. They are written whatever the enable bits are, and the same value appears on both `ctrl_a` and `ctrl_b`.
- R5: Registers 1, 2 and 3 have one copy per page. A write changes only the copies whose enable bit is set, and with neither bit set it changes none.
- R6: A write to address 0x1000 to 0x3AFF raises `bm_we_a` and/or `bm_we_b` for exactly one clock, according to the enable bits. `bm_addr` and `bm_wdata` carry the word's address and data during that clock.
- R7: A write to address 0x0008 to 0x0FFF, or to 0x3B00 and above, changes no register and produces no bitmap strobe. The burst address still advances past it.
- R8: While `rst_n` is low, all control registers read zero and no bitmap strobe is produced. Bitmap contents are left to the external memory.
- R9: A word with fewer than 16 bits when `cs_n` rises is discarded. The next low period of `cs_n` starts again with an address word.
- R10: Serial clock edges while `cs_n` is high shift nothing and cause no write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low serial select (asynchronous) |
| sck | input | 1 | Serial clock (asynchronous) |
| sdi | input | 1 | Serial data, LSB first (asynchronous) |
| ctrl_a | output | NREG x DW (8x16) | Register file as seen by page A |
| ctrl_b | output | NREG x DW (8x16) | Register file as seen by page B |
| bm_we_a | output | 1 | Bitmap write strobe, page A copy |
| bm_we_b | output | 1 | Bitmap write strobe, page B copy |
| bm_addr | output | AW (16) | Bitmap write address |
| bm_wdata | output | DW (16) | Bitmap write data |

## Verification
The hardest states to reach are the boundaries inside one auto-increment burst. One case is a burst that starts on the last reserved address and crosses into the bitmap window. Another starts on the last bitmap address and runs past the top of the window. The third is a transfer cut off part-way through a word. The bench reaches the first two by choosing start addresses 0x0FFF and 0x3AFF, so that consecutive data words fall on either side of each boundary. It reaches the third by raising `cs_n` after 9 or 7 bits and then showing that the next transfer still begins with a fresh address phase.

// File: rtl/sloader_pkg.sv
package sloader_pkg;
  localparam int AW = 16;
  localparam int DW = 16;
endpackage

// File: rtl/sl_shift_rx.sv
module sl_shift_rx
  import sloader_pkg::*;
#(
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          sck,
  input  logic          sdi,
  output logic          word_v,
  output logic [DW-1:0] word,
  output logic          word_is_addr
);
  localparam int CW = $clog2(DW);

  logic [SYNC-1:0] cs_sy, sck_sy, sd_sy;
  logic            cs_q, sck_q, sd_q, sck_prev, sck_rise;
  logic [CW-1:0]   cnt;
  logic [DW-1:0]   shreg;
  logic            first;

  // two-or-more stage synchronisers for the asynchronous serial pins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_sy  <= '1;
      sck_sy <= '0;
      sd_sy  <= '0;
    end else begin
      cs_sy  <= {cs_sy[SYNC-2:0], cs_n};
      sck_sy <= {sck_sy[SYNC-2:0], sck};
      sd_sy  <= {sd_sy[SYNC-2:0], sdi};
    end
  end

  assign cs_q     = cs_sy[SYNC-1];
  assign sck_q    = sck_sy[SYNC-1];
  assign sd_q     = sd_sy[SYNC-1];
  assign sck_rise = sck_q & ~sck_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_prev     <= 1'b0;
      cnt          <= '0;
      shreg        <= '0;
      first        <= 1'b1;
      word_v       <= 1'b0;
      word         <= '0;
      word_is_addr <= 1'b0;
    end else begin
      sck_prev <= sck_q;
      word_v   <= 1'b0;
      if (cs_q) begin
        cnt   <= '0;
        first <= 1'b1;
      end else if (sck_rise) begin
        shreg <= {sd_q, shreg[DW-1:1]};
        if (cnt == CW'(DW-1)) begin
          cnt          <= '0;
          word_v       <= 1'b1;
          word         <= {sd_q, shreg[DW-1:1]};
          word_is_addr <= first;
          first        <= 1'b0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  AST_WORD_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    word_v |=> !word_v); // R1
  AST_IDLE_NO_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    cs_q |=> !word_v); // R10
  AST_RESTART_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_q && !sck_rise) |=> (word_v -> word_is_addr)); // R9
endmodule

// File: rtl/sl_addr_seq.sv
module sl_addr_seq
  import sloader_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          word_v,
  input  logic [DW-1:0] word,
  input  logic          word_is_addr,
  output logic          wr_v,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data
);
  logic [AW-1:0] cur;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur     <= '0;
      wr_v    <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_v <= 1'b0;
      if (word_v) begin
        if (word_is_addr) begin
          cur <= AW'(word);
        end else begin
          wr_v    <= 1'b1;
          wr_addr <= cur;
          wr_data <= word;
          cur     <= cur + 1'b1;
        end
      end
    end
  end

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (word_v && !word_is_addr) |=> (wr_v && cur == wr_addr + 1'b1)); // R2
  AST_ADDR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (word_v && word_is_addr) |=> (!wr_v && cur == AW'($past(word)))); // R2
endmodule

// File: rtl/sl_write_router.sv
module sl_write_router
  import sloader_pkg::*;
#(
  parameter int            NREG       = 8,
  parameter logic [NREG-1:0] PAGED_MASK = 8'b0000_1110,
  parameter logic [AW-1:0] BM_LO      = 16'h1000,
  parameter logic [AW-1:0] BM_HI      = 16'h3AFF
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_v,
  input  logic [AW-1:0]            wr_addr,
  input  logic [DW-1:0]            wr_data,
  output logic [NREG-1:0][DW-1:0]  ctrl_a,
  output logic [NREG-1:0][DW-1:0]  ctrl_b,
  output logic                     bm_we_a,
  output logic                     bm_we_b,
  output logic [AW-1:0]            bm_addr,
  output logic [DW-1:0]            bm_wdata
);
  localparam int IW = (NREG > 1) ? $clog2(NREG) : 1;

  logic          en_a, en_b, is_reg, is_bm;
  logic [IW-1:0] idx;

  // page enables live in shared register 0
  assign en_a   = ctrl_a[0][0];
  assign en_b   = ctrl_a[0][1];
  assign is_reg = wr_addr < AW'(NREG);
  assign is_bm  = (wr_addr >= BM_LO) && (wr_addr <= BM_HI);
  assign idx    = wr_addr[IW-1:0];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic hit;
    assign hit = wr_v && is_reg && (idx == IW'(i));
    if (PAGED_MASK[i]) begin : g_paged
      logic [DW-1:0] qa, qb;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          qa <= '0;
          qb <= '0;
        end else begin
          if (hit && en_a) qa <= wr_data;
          if (hit && en_b) qb <= wr_data;
        end
      end
      assign ctrl_a[i] = qa;
      assign ctrl_b[i] = qb;
    end else begin : g_shared
      logic [DW-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   q <= '0;
        else if (hit) q <= wr_data;
      end
      assign ctrl_a[i] = q;
      assign ctrl_b[i] = q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bm_we_a  <= 1'b0;
      bm_we_b  <= 1'b0;
      bm_addr  <= '0;
      bm_wdata <= '0;
    end else begin
      bm_we_a <= wr_v && is_bm && en_a;
      bm_we_b <= wr_v && is_bm && en_b;
      if (wr_v && is_bm) begin
        bm_addr  <= wr_addr;
        bm_wdata <= wr_data;
      end
    end
  end

  AST_PROT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_v && !is_reg && !is_bm) |=> ($stable(ctrl_a) && $stable(ctrl_b) && !bm_we_a && !bm_we_b)); // R7
  AST_BM_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (bm_we_a || bm_we_b) |-> (bm_addr >= BM_LO && bm_addr <= BM_HI)); // R6
  AST_BM_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (bm_we_a || bm_we_b) |=> (!bm_we_a && !bm_we_b)); // R6
  AST_BM_GATE_A: assert property (@(posedge clk) disable iff (!rst_n)
    bm_we_a |-> ctrl_b[0][0]); // R3
  AST_BM_GATE_B: assert property (@(posedge clk) disable iff (!rst_n)
    bm_we_b |-> ctrl_a[0][1]); // R3
endmodule

// File: rtl/serial_reg_loader.sv
module serial_reg_loader
  import sloader_pkg::*;
#(
  parameter int              NREG       = 8,
  parameter logic [NREG-1:0] PAGED_MASK = 8'b0000_1110,
  parameter logic [AW-1:0]   BM_LO      = 16'h1000,
  parameter logic [AW-1:0]   BM_HI      = 16'h3AFF,
  parameter int              SYNC       = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cs_n,
  input  logic                    sck,
  input  logic                    sdi,
  output logic [NREG-1:0][DW-1:0] ctrl_a,
  output logic [NREG-1:0][DW-1:0] ctrl_b,
  output logic                    bm_we_a,
  output logic                    bm_we_b,
  output logic [AW-1:0]           bm_addr,
  output logic [DW-1:0]           bm_wdata
);
  logic          word_v, word_is_addr, wr_v;
  logic [DW-1:0] word, wr_data;
  logic [AW-1:0] wr_addr;

  sl_shift_rx #(.SYNC(SYNC)) u_rx (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi),
    .word_v(word_v), .word(word), .word_is_addr(word_is_addr)
  );

  sl_addr_seq u_seq (
    .clk(clk), .rst_n(rst_n), .word_v(word_v), .word(word),
    .word_is_addr(word_is_addr), .wr_v(wr_v), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  sl_write_router #(
    .NREG(NREG), .PAGED_MASK(PAGED_MASK), .BM_LO(BM_LO), .BM_HI(BM_HI)
  ) u_route (
    .clk(clk), .rst_n(rst_n), .wr_v(wr_v), .wr_addr(wr_addr), .wr_data(wr_data),
    .ctrl_a(ctrl_a), .ctrl_b(ctrl_b), .bm_we_a(bm_we_a), .bm_we_b(bm_we_b),
    .bm_addr(bm_addr), .bm_wdata(bm_wdata)
  );
endmodule

// File: tb/sim_serial_reg_loader.sv
module sim_serial_reg_loader;
  localparam int CLK_PERIOD = 10;
  localparam int LOGN = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1;
  logic sck = 1'b0;
  logic sdi = 1'b0;
  logic [7:0][15:0] ctrl_a, ctrl_b;
  logic bm_we_a, bm_we_b;
  logic [15:0] bm_addr, bm_wdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [15:0] lg_addr [LOGN];
  logic [15:0] lg_data [LOGN];
  logic        lg_a    [LOGN];
  logic        lg_b    [LOGN];
  int          log_n = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_reg_loader u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi),
    .ctrl_a(ctrl_a), .ctrl_b(ctrl_b), .bm_we_a(bm_we_a), .bm_we_b(bm_we_b),
    .bm_addr(bm_addr), .bm_wdata(bm_wdata)
  );

  // record every bitmap strobe, sampled away from the active edge
  always @(negedge clk) begin
    if (bm_we_a || bm_we_b) begin
      if (log_n < LOGN) begin
        lg_addr[log_n] = bm_addr;
        lg_data[log_n] = bm_wdata;
        lg_a[log_n]    = bm_we_a;
        lg_b[log_n]    = bm_we_b;
      end
      log_n = log_n + 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic sck_bit(input logic b);
    sdi = b;
    repeat (4) @(negedge clk);
    sck = 1'b1;
    repeat (4) @(negedge clk);
    sck = 1'b0;
  endtask

  task automatic send_bits(input logic [15:0] w, input int n);
    for (int i = 0; i < n; i++) sck_bit(w[i]);
  endtask

  task automatic cs_begin();
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic cs_end();
    repeat (4) @(negedge clk);
    cs_n = 1'b1;
    repeat (10) @(negedge clk);
  endtask

  task automatic frame(input logic [15:0] a, input logic [15:0] d0,
                       input logic [15:0] d1, input int nd);
    cs_begin();
    send_bits(a, 16);
    if (nd > 0) send_bits(d0, 16);
    if (nd > 1) send_bits(d1, 16);
    cs_end();
  endtask

  task automatic t_reset_state();
    chk("R8 ctrl_a zero in reset", 32'(ctrl_a == '0), 32'd1);
    chk("R8 ctrl_b zero in reset", 32'(ctrl_b == '0), 32'd1);
    chk("R8 no strobe in reset", 32'(log_n), 32'd0);
  endtask

  task automatic t_shared();
    frame(16'h0004, 16'hA5C3, 16'h1234, 2);
    chk("R1 LSB-first reg4 page A", 32'(ctrl_a[4]), 32'h0000A5C3);
    chk("R4 reg4 shared on page B", 32'(ctrl_b[4]), 32'h0000A5C3);
    chk("R2 auto-increment reg5", 32'(ctrl_a[5]), 32'h00001234);
    chk("R5 paged reg1 untouched", 32'(ctrl_a[1]), 32'h0);
  endtask

  task automatic t_paged();
    frame(16'h0000, 16'h0001, 16'h1111, 2);
    chk("R5 reg1 page A enabled", 32'(ctrl_a[1]), 32'h00001111);
    chk("R5 reg1 page B disabled", 32'(ctrl_b[1]), 32'h0);
    frame(16'h0000, 16'h0002, 16'hBBBB, 2);
    chk("R3 reg1 page B enabled", 32'(ctrl_b[1]), 32'h0000BBBB);
    chk("R3 reg1 page A now held", 32'(ctrl_a[1]), 32'h00001111);
    cs_begin();
    send_bits(16'h0000, 16); send_bits(16'h0003, 16);
    send_bits(16'h3333, 16); send_bits(16'h4444, 16);
    cs_end();
    chk("R3 both pages reg1 A", 32'(ctrl_a[1]), 32'h00003333);
    chk("R3 both pages reg1 B", 32'(ctrl_b[1]), 32'h00003333);
    chk("R3 both pages reg2 B", 32'(ctrl_b[2]), 32'h00004444);
    chk("R4 reg0 same on both views", 32'(ctrl_b[0]), 32'h00000003);
    frame(16'h0000, 16'h0000, 16'h5555, 2);
    chk("R5 no enable keeps reg1 A", 32'(ctrl_a[1]), 32'h00003333);
    chk("R5 no enable keeps reg1 B", 32'(ctrl_b[1]), 32'h00003333);
  endtask

  task automatic t_bitmap();
    int n0;
    frame(16'h0000, 16'h0001, 16'h0, 1);
    n0 = log_n;
    frame(16'h1000, 16'hBEEF, 16'h1357, 2);
    chk("R6 two strobes page A", 32'(log_n - n0), 32'd2);
    chk("R6 first addr", 32'(lg_addr[n0]), 32'h1000);
    chk("R6 first data", 32'(lg_data[n0]), 32'hBEEF);
    chk("R3 A only first strobe", 32'({lg_a[n0], lg_b[n0]}), 32'b10);
    chk("R2 second addr increments", 32'(lg_addr[n0+1]), 32'h1001);
    chk("R6 second data", 32'(lg_data[n0+1]), 32'h1357);
    frame(16'h0000, 16'h0003, 16'h0, 1);
    n0 = log_n;
    frame(16'h3AFF, 16'hCAFE, 16'h0F0F, 2);
    chk("R7 past window top one strobe", 32'(log_n - n0), 32'd1);
    chk("R6 top address", 32'(lg_addr[n0]), 32'h3AFF);
    chk("R3 both pages strobe", 32'({lg_a[n0], lg_b[n0]}), 32'b11);
  endtask

  task automatic t_protect();
    logic [7:0][15:0] sa, sb;
    int n0;
    sa = ctrl_a; sb = ctrl_b; n0 = log_n;
    frame(16'h0FFF, 16'h7777, 16'h8888, 2);
    chk("R7 reserved leaves ctrl_a", 32'(ctrl_a == sa), 32'd1);
    chk("R7 reserved leaves ctrl_b", 32'(ctrl_b == sb), 32'd1);
    chk("R7 reserved then bitmap one strobe", 32'(log_n - n0), 32'd1);
    chk("R2 crossing to 0x1000", 32'(lg_addr[n0]), 32'h1000);
    chk("R6 crossing data", 32'(lg_data[n0]), 32'h8888);
    n0 = log_n;
    frame(16'h0007, 16'h00F0, 16'h9999, 2);
    sa[7] = 16'h00F0; sb[7] = 16'h00F0;
    chk("R7 reg7 then 0x0008 ignored A", 32'(ctrl_a == sa), 32'd1);
    chk("R7 reg7 then 0x0008 ignored B", 32'(ctrl_b == sb), 32'd1);
    chk("R7 no strobe for 0x0008", 32'(log_n - n0), 32'd0);
  endtask

  task automatic t_partial();
    logic [7:0][15:0] sa;
    cs_begin(); send_bits(16'hFFFF, 9); cs_end();
    frame(16'h0005, 16'h0ABC, 16'h0, 1);
    chk("R9 restart after partial", 32'(ctrl_a[5]), 32'h00000ABC);
    sa = ctrl_a;
    cs_begin();
    send_bits(16'h0006, 16); send_bits(16'h1234, 16); send_bits(16'hFFFF, 7);
    cs_end();
    chk("R9 full word kept", 32'(ctrl_a[6]), 32'h00001234);
    chk("R9 partial word dropped", 32'(ctrl_a[7]), 32'(sa[7]));
  endtask

  task automatic t_idle_clock();
    logic [7:0][15:0] sa;
    int n0;
    sa = ctrl_a; n0 = log_n;
    for (int i = 0; i < 20; i++) sck_bit(1'b1);
    repeat (10) @(negedge clk);
    chk("R10 idle clocks no change", 32'(ctrl_a == sa), 32'd1);
    chk("R10 idle clocks no strobe", 32'(log_n - n0), 32'd0);
    sdi = 1'b0;
    frame(16'h0004, 16'h00C3, 16'h0, 1);
    chk("R10 clean word after idle", 32'(ctrl_a[4]), 32'h000000C3);
  endtask

  task automatic t_reset_again();
    int n0;
    n0 = log_n;
    @(negedge clk) rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8 reset clears ctrl_a", 32'(ctrl_a == '0), 32'd1);
    chk("R8 reset clears ctrl_b", 32'(ctrl_b == '0), 32'd1);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R8 no strobe from reset", 32'(log_n - n0), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset_state();
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_shared();
    t_paged();
    t_bitmap();
    t_protect();
    t_partial();
    t_idle_clock();
    t_reset_again();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog all-requirements actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule